// File: doc/BRIEF.md
# Bi-phase Mark Line Encoder

This block turns a stream of already formatted audio subframes into one serial line using bi-phase mark coding. Each subframe occupies 64 line states. The first eight states carry a synchronisation preamble that breaks the coding rule on purpose. The remaining 56 states carry 28 payload bits, two states per bit. The line advances by one state on each clock cycle where the state-rate enable is high. That enable runs at twice the bit rate, which gives 64 states per sample period.

An upstream framer offers one subframe at a time through a valid/ready handshake: a 28-bit payload and a two-bit preamble kind. A one-entry holding register decouples that handshake from the line timing. When a subframe ends and nothing new is held, the encoder raises a one-cycle underflow flag and sends the previous subframe again. The mute input forces the line low. While muted, the encoder keeps coding internally, so releasing mute resumes the stream exactly where it would have been.

Top module: `bmc_line_encoder`

## Requirements
- R1: After reset, line_out is low, sf_ready is high and underflow is low. State enables that arrive before any subframe has been accepted leave line_out low.
- R2: A subframe lasts exactly 64 line states, one per clock cycle with state_en high. The next subframe begins on the very next enable. line_out changes only on clock edges where state_en was high.
- R3: The first state of every payload bit is the inverse of the state sent just before it.
- R4: Payload bits go out in index order 0 to 27 after the preamble. For a 0 bit, the second state repeats the first. For a 1 bit, the second state inverts the first.
- R5: If the last state before a subframe is 0, the preamble is sent leftmost state first. Kind code 0 sends 11101000, code 1 sends 11100010, code 2 sends 11100100, and code 3 is treated as code 1.
- R6: If the last state before a subframe is 1, the preamble is the bitwise complement of the R5 pattern for the same kind. A preamble therefore always ends at the level it started from.
- R7: sf_ready is high exactly when the holding register is empty. A subframe is accepted on a clock edge where sf_valid and sf_ready are both high. sf_ready stays low until the encoder takes the held subframe at the start of a new subframe.
- R8: If nothing is held when a subframe ends (and one has been sent before), the encoder repeats the last payload and kind. The repeated preamble polarity is chosen from the current line level. underflow is high for exactly the one clock cycle that follows that boundary enable.
- R9: While mute is high, line_out is low. Coding continues internally, so after mute is released the line matches the uninterrupted stream.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| state_en | input | 1 | One-cycle pulse per line state period |
| mute | input | 1 | Forces the line low while high |
| sf_valid | input | 1 | Upstream subframe offered |
| sf_ready | output | 1 | Holding register empty, subframe can be accepted |
| sf_payload | input | 28 | Payload bits, bit 0 sent first |
| sf_kind | input | 2 | Preamble kind: 0, 1, 2 (3 behaves as 1) |
| line_out | output | 1 | Encoded line state |
| underflow | output | 1 | One-cycle pulse when a subframe is repeated |

## Verification
Each line state is registered on the clock edge where state_en is high and appears on line_out right after that edge. The monitor samples at the following falling edge, but only after edges it recorded as enable edges. The underflow pulse belongs to the same edge as the first state of the repeated subframe, so it is compared against a flag carried in that queue entry. sf_ready falls one edge after acceptance and is checked at the next falling edge. mute acts combinationally, so the expected value at each sample uses the mute level at that moment.

// File: rtl/bmc_pkg.sv
package bmc_pkg;

    typedef enum logic [1:0] {
        PRE_BLOCK = 2'd0,
        PRE_CH1   = 2'd1,
        PRE_CH2   = 2'd2,
        PRE_RSV   = 2'd3
    } pre_kind_e;

    localparam int PRE_STATES = 8;

    // Pattern for a preceding line level of 0, leftmost state sent first.
    function automatic logic [PRE_STATES-1:0] pre_pattern(input pre_kind_e kind);
        logic [PRE_STATES-1:0] pat;
        case (kind)
            PRE_BLOCK: pat = 8'b1110_1000;
            PRE_CH2:   pat = 8'b1110_0100;
            default:   pat = 8'b1110_0010;
        endcase
        return pat;
    endfunction

endpackage

// File: rtl/bmc_hold_buf.sv
module bmc_hold_buf #(
    parameter int W = 30
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    input  logic [W-1:0] in_data,
    output logic         in_ready,
    input  logic         take,
    output logic         full,
    output logic [W-1:0] data
);

    typedef struct packed {
        logic         full;
        logic [W-1:0] data;
    } hold_t;

    hold_t hold_d, hold_q;

    always_comb begin
        hold_d = hold_q;
        if (take) begin
            hold_d.full = 1'b0;
        end
        if (in_valid && !hold_q.full) begin
            hold_d.full = 1'b1;
            hold_d.data = in_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q <= '0;
        end else begin
            hold_q <= hold_d;
        end
    end

    assign in_ready = !hold_q.full;
    assign full     = hold_q.full;
    assign data     = hold_q.data;

    // R7: a held subframe stays put until the encoder takes it
    assert_hold_kept_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_q.full && !take) |=> (hold_q.full && $stable(hold_q.data)));

endmodule

// File: rtl/bmc_preamble_gen.sv
module bmc_preamble_gen
    import bmc_pkg::*;
(
    input  pre_kind_e   kind,
    input  logic        pol,
    input  logic [2:0]  idx,
    output logic        state
);

    logic [PRE_STATES-1:0] pat;

    always_comb begin
        pat   = pre_pattern(kind) ^ {PRE_STATES{pol}};
        state = pat[3'(PRE_STATES-1) - idx];
    end

endmodule

// File: rtl/bmc_symbol_map.sv
module bmc_symbol_map (
    input  logic prev_level,
    input  logic bit_val,
    input  logic second_half,
    output logic state
);

    always_comb begin
        if (second_half) begin
            state = bit_val ? ~prev_level : prev_level;
        end else begin
            state = ~prev_level;
        end
    end

endmodule

// File: rtl/bmc_line_encoder.sv
module bmc_line_encoder
    import bmc_pkg::*;
#(
    parameter int PAYLOAD_W = 28,
    parameter int PRE_SLOTS = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 state_en,
    input  logic                 mute,
    input  logic                 sf_valid,
    output logic                 sf_ready,
    input  logic [PAYLOAD_W-1:0] sf_payload,
    input  logic [1:0]           sf_kind,
    output logic                 line_out,
    output logic                 underflow
);

    localparam int SLOTS   = PRE_SLOTS + PAYLOAD_W;
    localparam int STATES  = 2 * SLOTS;
    localparam int POS_W   = $clog2(STATES);
    localparam int HOLD_W  = PAYLOAD_W + 2;

    typedef struct packed {
        logic [POS_W-1:0]     pos;
        logic [PAYLOAD_W-1:0] payload;
        pre_kind_e            kind;
        logic                 running;
        logic                 pol;
        logic                 line;
        logic                 uflow;
    } enc_t;

    enc_t enc_d, enc_q;

    logic                 hold_full;
    logic [HOLD_W-1:0]    hold_data;
    logic                 take;
    logic                 at_start;
    logic [PAYLOAD_W-1:0] cur_payload;
    pre_kind_e            cur_kind;
    logic                 pre_pol;
    logic                 in_pre;
    logic [POS_W-1:0]     didx;
    logic [PAYLOAD_W-1:0] shifted;
    logic                 pre_state;
    logic                 sym_state;
    logic                 emit;

    bmc_hold_buf #(.W(HOLD_W)) u_hold (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (sf_valid),
        .in_data  ({sf_kind, sf_payload}),
        .in_ready (sf_ready),
        .take     (take),
        .full     (hold_full),
        .data     (hold_data)
    );

    assign at_start    = (enc_q.pos == '0);
    assign take        = state_en && at_start && hold_full;
    assign cur_payload = take ? hold_data[PAYLOAD_W-1:0] : enc_q.payload;
    assign cur_kind    = take ? pre_kind_e'(hold_data[HOLD_W-1:PAYLOAD_W]) : enc_q.kind;
    assign pre_pol     = at_start ? enc_q.line : enc_q.pol;
    assign in_pre      = (enc_q.pos < POS_W'(PRE_STATES));
    assign didx        = (enc_q.pos >> 1) - POS_W'(PRE_SLOTS);
    assign shifted     = cur_payload >> didx;
    assign emit        = state_en && (!at_start || take || enc_q.running);

    bmc_preamble_gen u_pre (
        .kind  (cur_kind),
        .pol   (pre_pol),
        .idx   (enc_q.pos[2:0]),
        .state (pre_state)
    );

    bmc_symbol_map u_sym (
        .prev_level  (enc_q.line),
        .bit_val     (shifted[0]),
        .second_half (enc_q.pos[0]),
        .state       (sym_state)
    );

    always_comb begin
        enc_d       = enc_q;
        enc_d.uflow = state_en && at_start && !hold_full && enc_q.running;
        if (emit) begin
            enc_d.line = in_pre ? pre_state : sym_state;
            enc_d.pos  = (enc_q.pos == POS_W'(STATES - 1)) ? '0 : enc_q.pos + 1'b1;
            if (at_start) begin
                enc_d.pol = enc_q.line;
            end
            if (take) begin
                enc_d.payload = cur_payload;
                enc_d.kind    = cur_kind;
                enc_d.running = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            enc_q <= '0;
        end else begin
            enc_q <= enc_d;
        end
    end

    assign line_out  = enc_q.line & ~mute;
    assign underflow = enc_q.uflow;

    // R2: the line only moves on enable edges
    assert_hold_without_enable_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !state_en |=> $stable(enc_q.line));

    // R3: first half of every payload symbol flips the line
    assert_first_half_flips_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_en && enc_q.pos >= POS_W'(PRE_STATES) && !enc_q.pos[0])
            |=> (enc_q.line != $past(enc_q.line)));

    // R6: every preamble ends at the level that preceded it
    assert_preamble_end_level_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_en && enc_q.pos == POS_W'(PRE_STATES - 1)) |=> (enc_q.line == enc_q.pol));

    // R8: underflow only follows an enable at a subframe boundary with nothing held
    assert_underflow_on_boundary_R8: assert property (@(posedge clk) disable iff (!rst_n)
        enc_q.uflow |-> ($past(state_en) && $past(enc_q.pos) == '0 && !$past(hold_full)));

endmodule

// File: tb/bmc_line_encoder_test.sv
module bmc_line_encoder_test;

    localparam int CLK_PERIOD = 10;
    localparam int PW         = 28;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          state_en = 1'b0;
    logic          mute = 1'b0;
    logic          sf_valid = 1'b0;
    logic [PW-1:0] sf_payload = '0;
    logic [1:0]    sf_kind = 2'd0;
    logic          sf_ready;
    logic          line_out;
    logic          underflow;

    int            checks = 0;
    int            fails = 0;
    logic [2:0]    exp_q[$];
    logic          model_lvl = 1'b0;
    logic [PW-1:0] last_pl = '0;
    logic [1:0]    last_kind = 2'd0;
    bit            en_go = 1'b0;
    logic          en_at_edge = 1'b0;
    int            uf_seen = 0;
    logic          prev_out = 1'b0;
    logic          prev_mute = 1'b0;

    bmc_line_encoder uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .state_en   (state_en),
        .mute       (mute),
        .sf_valid   (sf_valid),
        .sf_ready   (sf_ready),
        .sf_payload (sf_payload),
        .sf_kind    (sf_kind),
        .line_out   (line_out),
        .underflow  (underflow)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) en_at_edge <= state_en;

    task automatic check(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    function automatic logic [7:0] pat_of(input logic [1:0] k);
        case (k)
            2'd0:    return 8'b1110_1000;
            2'd2:    return 8'b1110_0100;
            default: return 8'b1110_0010;
        endcase
    endfunction

    // Scoreboard entry: {underflow expected, preamble polarity, line state}
    task automatic push_model(input logic [1:0] k, input logic [PW-1:0] pl, input bit uf);
        logic [7:0] p;
        logic       pol;
        logic       s1;
        logic       s2;
        pol = model_lvl;
        p = pat_of(k) ^ {8{pol}};
        for (int i = 7; i >= 0; i--) begin
            exp_q.push_back({(i == 7) ? uf : 1'b0, pol, p[i]});
        end
        model_lvl = p[0];
        for (int i = 0; i < PW; i++) begin
            s1 = ~model_lvl;
            exp_q.push_back({1'b0, pol, s1});
            s2 = pl[i] ? ~s1 : s1;
            exp_q.push_back({1'b0, pol, s2});
            model_lvl = s2;
        end
        last_pl   = pl;
        last_kind = k;
    endtask

    task automatic send(input logic [1:0] k, input logic [PW-1:0] pl);
        bit done;
        done = 1'b0;
        while (!done) begin
            @(negedge clk);
            if (sf_ready) begin
                sf_valid   = 1'b1;
                sf_kind    = k;
                sf_payload = pl;
                @(posedge clk);
                #1;
                push_model(k, pl, 1'b0);
                @(negedge clk);
                sf_valid = 1'b0;
                check(sf_ready == 1'b0, "R7 ready low while held", int'(sf_ready), 0);
                done = 1'b1;
            end
        end
    endtask

    // Monitor: pops one expected state per enable edge
    initial begin
        int pos;
        logic [2:0] e;
        logic expv;
        pos = 0;
        forever begin
            @(negedge clk);
            if (en_go && exp_q.size() > 0) begin
                if (en_at_edge) begin
                    e = exp_q.pop_front();
                    expv = mute ? 1'b0 : e[0];
                    if (mute)
                        check(line_out === expv, "R9 muted line", int'(line_out), int'(expv));
                    else if (pos < 8)
                        check(line_out === expv, e[1] ? "R6 preamble after high" : "R5 preamble after low",
                              int'(line_out), int'(expv));
                    else if (pos[0])
                        check(line_out === expv, "R4 second state", int'(line_out), int'(expv));
                    else
                        check(line_out === expv, "R3 first state", int'(line_out), int'(expv));
                    check(underflow === e[2], "R8 underflow timing", int'(underflow), int'(e[2]));
                    if (underflow) uf_seen++;
                    pos = (pos == 63) ? 0 : pos + 1;
                end else begin
                    if (mute == prev_mute)
                        check(line_out === prev_out, "R2 hold between enables", int'(line_out), int'(prev_out));
                    check(underflow === 1'b0, "R8 no stray underflow", int'(underflow), 0);
                end
            end
            prev_out  = line_out;
            prev_mute = mute;
        end
    end

    // State-rate enable: one pulse every four clocks
    initial begin
        wait (en_go);
        forever begin
            @(negedge clk) state_en = 1'b1;
            @(negedge clk) state_en = 1'b0;
            repeat (2) @(negedge clk);
        end
    end

    // Mute window in the middle of the stream
    initial begin
        wait (en_go);
        repeat (700) @(negedge clk);
        mute = 1'b1;
        repeat (60) @(negedge clk);
        mute = 1'b0;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check(line_out == 1'b0, "R1 line low after reset", int'(line_out), 0);
        check(sf_ready == 1'b1, "R1 ready after reset", int'(sf_ready), 1);
        check(underflow == 1'b0, "R1 no underflow after reset", int'(underflow), 0);
        // R1: enables with nothing accepted emit nothing
        for (int i = 0; i < 3; i++) begin
            @(negedge clk) state_en = 1'b1;
            @(negedge clk) state_en = 1'b0;
            check(line_out == 1'b0, "R1 idle before first subframe", int'(line_out), 0);
            check(underflow == 1'b0, "R1 idle no underflow", int'(underflow), 0);
        end
        send(2'd0, '0);
        repeat (3) @(negedge clk);
        check(sf_ready == 1'b0, "R7 ready stays low until taken", int'(sf_ready), 0);
        en_go = 1'b1;
        send(2'd2, {PW{1'b1}});
        send(2'd1, {(PW/2){2'b10}});
        send(2'd2, 28'(32'($urandom)));
        send(2'd1, 28'(32'($urandom)));
        send(2'd3, 28'(32'($urandom)));
        send(2'd0, 28'h0000001);
        send(2'd2, 28'h8000000);
        send(2'd1, 28'(32'($urandom)));
        // R8: starve the encoder once
        push_model(last_kind, last_pl, 1'b1);
        wait (uf_seen > 0);
        send(2'd2, 28'(32'($urandom)));
        wait (exp_q.size() == 0);
        repeat (2) @(negedge clk);
        check(uf_seen == 1, "R8 single underflow pulse", uf_seen, 1);
        check(exp_q.size() == 0, "R2 all states emitted", exp_q.size(), 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule